// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block moves bytes between time slots of serial TDM streams. A frame pulse and a single bit clock time all streams. During each frame, every input stream is turned from serial bits into channel bytes, and those bytes are stored in a data store with two banks. Each frame writes one bank while the other bank, which holds the previous frame, is read. Every byte therefore passes through the switch with a delay of exactly one frame, whatever its source and destination slots are. This constant delay keeps the bytes of a multi-slot connection in the same frame.

A connection table has one entry for each output stream and channel. An entry can select a source stream and channel, which is the switched mode. It can instead supply a literal byte to send, which is the message mode. Two control bits in the entry can release the output to high impedance or force it to all ones. A host port writes entries into a shadow copy of the table. The shadow copy becomes the live table at the next frame pulse. The host port can also read back table entries and read bytes from the data store to monitor channels.

Each stream runs at one of two rates. The fast rate carries 64 channels with one clock per bit. The slow rate carries 32 channels with two clocks per bit. After reset, a small start-up state machine counts frame pulses. Its states are ST_WAIT_FIRST, ST_WAIT_SECOND and ST_SWITCHING. The transitions are: ST_WAIT_FIRST to ST_WAIT_SECOND on the first pulse, ST_WAIT_SECOND to ST_SWITCHING on the second pulse, and ST_SWITCHING stays in ST_SWITCHING. The outputs are released only at the second pulse.

Top module: `tdm_tsi_switch`

## Requirements
- R1: In switched mode, output stream o, channel c carries the byte that the entry's source stream and channel received in the previous frame. Entry layout: bits [7:0] message byte, [13:8] source channel, [14] source stream, [15] message mode, [16] high impedance, [17] force ones. The index of the entry is {o, c}, with o at bit 6.
- R2: When bit 15 is set and bits 16 and 17 are clear, the output channel carries entry bits [7:0].
- R3: When bit 16 is set, ser_oe is low for every bit time of that channel, whatever bits 15 and 17 hold.
- R4: When bit 17 is set and bit 16 is clear, ser_out is 1 with ser_oe high for the whole channel.
- R5: Rate bit 1 means 64 channels of 8 bits with one clock per bit. Rate bit 0 means 32 channels with two clocks per bit. Bits are sent MSB first. The clock edge at which fp_i is high samples channel 0, bit 7, and the output for position k appears on the clock edge that samples position k.
- R6: ser_oe stays low until the second frame pulse after reset. Switching starts with the frame that the second pulse opens.
- R7: A host write to the connection table changes an output channel only from the frame that starts after the write.
- R8: With host_sel = 0, host_rdata returns the shadow table entry at host_addr one cycle later.
- R9: With host_sel = 1, host_rdata[7:0] returns one cycle later the data store byte of stream host_addr[6] and channel host_addr[5:0]. The byte comes from the bank being read for switching, which is the frame before the current one.
- R10: A host write with host_sel = 1 changes neither the data store nor the table.
- R11: Reset drives ser_oe low and loads every table entry with only the high impedance bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fp_i | input | 1 | Frame pulse, marking channel 0 bit 7 |
| rate_in | input | NSTR | Per input stream rate, 1 = fast |
| rate_out | input | NSTR | Per output stream rate, 1 = fast |
| ser_in | input | NSTR | Serial input streams |
| ser_out | output | NSTR | Serial output data |
| ser_oe | output | NSTR | Output drive enable per stream |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 1 | 0 = connection table, 1 = data store |
| host_addr | input | 7 | {stream, channel} |
| host_wdata | input | 18 | Entry to write |
| host_rdata | output | 18 | Read data, one cycle latency |

## Verification
The assertions check the following on every cycle:
- The start-up sequence only moves forward, and ser_oe stays low while switching is not allowed.
- The data bank flips on every frame pulse.
- The bit position restarts after each pulse.
- The live table never changes in the middle of a frame.

Only the bench scenarios can show the byte contents and the priority among the entry modes. They cover the one-frame delay across mixed rates, a table write in the middle of a frame that must wait for the next boundary, host reads, and an ignored write to the data store.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
    typedef enum logic [1:0] {
        ST_WAIT_FIRST  = 2'd0,
        ST_WAIT_SECOND = 2'd1,
        ST_SWITCHING   = 2'd2
    } run_state_t;
endpackage

// File: rtl/tsi_frame_ctl.sv
module tsi_frame_ctl
    import tsi_pkg::*;
#(
    parameter int POS_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fp,
    output logic [POS_W-1:0] pos,
    output logic             wr_bank,
    output logic             rd_bank,
    output logic             go,
    output run_state_t       state
);
    logic [POS_W-1:0] cnt_q;
    logic             bank_q;
    run_state_t       state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            bank_q <= 1'b0;
        end else begin
            cnt_q  <= fp ? POS_W'(1) : cnt_q + 1'b1;
            if (fp) bank_q <= ~bank_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT_FIRST;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_FIRST:  if (fp) state_d = ST_WAIT_SECOND;
            ST_WAIT_SECOND: if (fp) state_d = ST_SWITCHING;
            ST_SWITCHING:   state_d = ST_SWITCHING;
            default:        state_d = ST_WAIT_FIRST;
        endcase
    end

    always_comb begin
        go = 1'b0;
        unique case (state_q)
            ST_WAIT_FIRST:  go = 1'b0;
            ST_WAIT_SECOND: go = fp;
            ST_SWITCHING:   go = 1'b1;
            default:        go = 1'b0;
        endcase
    end

    assign pos     = fp ? '0 : cnt_q;
    assign wr_bank = bank_q;
    assign rd_bank = fp ? bank_q : ~bank_q;
    assign state   = state_q;
endmodule

// File: rtl/tsi_rx_lane.sv
module tsi_rx_lane #(
    parameter int POS_W = 9,
    parameter int CHW   = POS_W - 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic             fast,
    input  logic [POS_W-1:0] pos,
    output logic             we,
    output logic [CHW-1:0]   ch,
    output logic [7:0]       byte_o
);
    logic [6:0] sh_q;
    logic       sample;
    logic [2:0] bit_idx;

    assign sample  = fast | pos[0];
    assign bit_idx = fast ? pos[2:0] : pos[3:1];
    assign ch      = fast ? pos[POS_W-1:3] : CHW'(pos[POS_W-1:4]);
    assign we      = sample && (bit_idx == 3'd7);
    assign byte_o  = {sh_q, din};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sh_q <= '0;
        else if (sample) sh_q <= {sh_q[5:0], din};
    end
endmodule

// File: rtl/tsi_dmem.sv
module tsi_dmem #(
    parameter int NSTR = 2,
    parameter int SW   = 1,
    parameter int CHW  = 6,
    parameter int NRD  = 3,
    localparam int AW  = 1 + SW + CHW,
    localparam int NWD = 1 << AW
) (
    input  logic           clk,
    input  logic           wr_bank,
    input  logic           we     [NSTR],
    input  logic [CHW-1:0] wch    [NSTR],
    input  logic [7:0]     wdat   [NSTR],
    input  logic [AW-1:0]  rd_addr[NRD],
    output logic [7:0]     rd_data[NRD]
);
    logic [7:0] mem [NWD];

    always_ff @(posedge clk) begin
        for (int s = 0; s < NSTR; s++) begin
            if (we[s]) mem[{wr_bank, SW'(s), wch[s]}] <= wdat[s];
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rd_data[r] = mem[rd_addr[r]];
    end
endmodule

// File: rtl/tdm_tsi_switch.sv
module tdm_tsi_switch
    import tsi_pkg::*;
#(
    parameter int NSTR  = 2,
    parameter int POS_W = 9,
    localparam int CHW  = POS_W - 3,
    localparam int SW   = $clog2(NSTR),
    localparam int EW   = SW + CHW,
    localparam int NENT = 1 << EW,
    localparam int CM_W = 8 + CHW + SW + 3,
    localparam int B_MSG  = 8 + CHW + SW,
    localparam int B_HIZ  = B_MSG + 1,
    localparam int B_ONES = B_MSG + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fp_i,
    input  logic [NSTR-1:0] rate_in,
    input  logic [NSTR-1:0] rate_out,
    input  logic [NSTR-1:0] ser_in,
    output logic [NSTR-1:0] ser_out,
    output logic [NSTR-1:0] ser_oe,
    input  logic            host_we,
    input  logic            host_sel,
    input  logic [EW-1:0]   host_addr,
    input  logic [CM_W-1:0] host_wdata,
    output logic [CM_W-1:0] host_rdata
);
    localparam logic [CM_W-1:0] RST_ENTRY = CM_W'(1) << B_HIZ;

    logic [POS_W-1:0] pos;
    logic             wr_bank, rd_bank, go;
    run_state_t       state;

    tsi_frame_ctl #(.POS_W(POS_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .fp(fp_i), .pos(pos),
        .wr_bank(wr_bank), .rd_bank(rd_bank), .go(go), .state(state)
    );

    logic           rx_we  [NSTR];
    logic [CHW-1:0] rx_ch  [NSTR];
    logic [7:0]     rx_byte[NSTR];

    for (genvar s = 0; s < NSTR; s++) begin : g_rx
        tsi_rx_lane #(.POS_W(POS_W), .CHW(CHW)) u_rx (
            .clk(clk), .rst_n(rst_n), .din(ser_in[s]), .fast(rate_in[s]),
            .pos(pos), .we(rx_we[s]), .ch(rx_ch[s]), .byte_o(rx_byte[s])
        );
    end

    logic [1+EW-1:0] rd_addr[NSTR+1];
    logic [7:0]      rd_data[NSTR+1];

    tsi_dmem #(.NSTR(NSTR), .SW(SW), .CHW(CHW), .NRD(NSTR+1)) u_dm (
        .clk(clk), .wr_bank(wr_bank), .we(rx_we), .wch(rx_ch), .wdat(rx_byte),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    logic [NENT-1:0][CM_W-1:0] cm_sh, cm_act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cm_sh  <= {NENT{RST_ENTRY}};
            cm_act <= {NENT{RST_ENTRY}};
        end else begin
            if (host_we && !host_sel) cm_sh[host_addr] <= host_wdata;
            if (fp_i) cm_act <= cm_sh;
        end
    end

    assign rd_addr[NSTR] = {rd_bank, host_addr};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) host_rdata <= '0;
        else        host_rdata <= host_sel ? CM_W'(rd_data[NSTR]) : cm_sh[host_addr];
    end

    logic [NSTR-1:0] out_d, oe_d;

    for (genvar o = 0; o < NSTR; o++) begin : g_tx
        localparam logic [SW-1:0] OI = SW'(o);
        logic [CHW-1:0]  ch;
        logic [2:0]      bsel;
        logic [CM_W-1:0] ent;
        logic [7:0]      sel_byte;

        assign ch   = rate_out[o] ? pos[POS_W-1:3] : CHW'(pos[POS_W-1:4]);
        assign bsel = rate_out[o] ? pos[2:0] : pos[3:1];
        assign ent  = fp_i ? cm_sh[{OI, ch}] : cm_act[{OI, ch}];
        assign rd_addr[o] = {rd_bank, ent[8+CHW +: SW], ent[8 +: CHW]};
        assign sel_byte   = ent[B_MSG] ? ent[7:0] : rd_data[o];
        assign oe_d[o]    = go & ~ent[B_HIZ];
        assign out_d[o]   = go & (ent[B_ONES] | sel_byte[3'd7 - bsel]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ser_out <= '0;
            ser_oe  <= '0;
        end else begin
            ser_out <= out_d;
            ser_oe  <= oe_d;
        end
    end
endmodule

// File: rtl/tsi_checker.sv
module tsi_checker
    import tsi_pkg::*;
#(
    parameter int NSTR  = 2,
    parameter int POS_W = 9,
    parameter int NENT  = 128,
    parameter int CM_W  = 18
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      fp_i,
    input logic                      go,
    input logic                      wr_bank,
    input logic [POS_W-1:0]          pos,
    input run_state_t                state,
    input logic [NENT-1:0][CM_W-1:0] cm_act,
    input logic [NSTR-1:0]           ser_oe
);
    AST_OE_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> ser_oe == '0); // R6
    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SWITCHING |=> state == ST_SWITCHING); // R6
    AST_BANK_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        fp_i |=> wr_bank != $past(wr_bank)); // R1
    AST_POS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        fp_i |=> (fp_i || pos == POS_W'(1))); // R5
    AST_TABLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !fp_i |=> $stable(cm_act)); // R7
endmodule

bind tdm_tsi_switch tsi_checker #(
    .NSTR(NSTR), .POS_W(POS_W), .NENT(NENT), .CM_W(CM_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .fp_i(fp_i), .go(go), .wr_bank(wr_bank),
    .pos(pos), .state(state), .cm_act(cm_act), .ser_oe(ser_oe)
);

// File: tb/tdm_tsi_switch_tb_top.sv
`timescale 1ns/1ps
module tdm_tsi_switch_tb_top;
    localparam int NSTR = 2;
    localparam int FRAME = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fp_i = 1'b0;
    logic [1:0]  rate_in = 2'b01;
    logic [1:0]  rate_out = 2'b10;
    logic [1:0]  ser_in = 2'b00;
    logic [1:0]  ser_out, ser_oe;
    logic        host_we = 1'b0;
    logic        host_sel = 1'b0;
    logic [6:0]  host_addr = '0;
    logic [17:0] host_wdata = '0;
    logic [17:0] host_rdata;

    always #2.5 clk = ~clk;

    tdm_tsi_switch dut_i (
        .clk(clk), .rst_n(rst_n), .fp_i(fp_i), .rate_in(rate_in), .rate_out(rate_out),
        .ser_in(ser_in), .ser_out(ser_out), .ser_oe(ser_oe), .host_we(host_we),
        .host_sel(host_sel), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata)
    );

    int n_tests = 0;
    int n_fail  = 0;
    logic [17:0] shadow [128];
    logic [17:0] snap   [128];

    // rows: {out stream, out channel, entry}
    localparam logic [24:0] VEC [8] = '{
        {1'b0, 6'd3,  18'h0803C},  // message 0x3C       R2
        {1'b0, 6'd10, 18'h10000},  // high impedance     R3
        {1'b0, 6'd20, 18'h20000},  // force ones         R4
        {1'b1, 6'd7,  18'h080C3},  // message 0xC3       R2
        {1'b1, 6'd40, 18'h10000},  // high impedance     R3
        {1'b1, 6'd63, 18'h20000},  // force ones         R4
        {1'b0, 6'd31, 18'h30000},  // hiz beats ones     R3
        {1'b1, 6'd0,  18'h05F00}   // slow stream 1 ch31 R1
    };

    function automatic logic [7:0] pat(int f, int s, int c);
        return 8'(f * 37 + s * 101 + c * 13 + 5);
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hwrite(logic sel, logic [6:0] a, logic [17:0] d);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_addr = a; host_wdata = d;
        if (!sel) shadow[a] = d;
        @(negedge clk);
        host_we = 1'b0; host_sel = 1'b0;
    endtask

    task automatic hread(logic sel, logic [6:0] a, output logic [17:0] d);
        @(negedge clk);
        host_sel = sel; host_addr = a;
        @(posedge clk);
        #1 d = host_rdata;
        host_sel = 1'b0;
    endtask

    // kinds: 0 conn, 1 msg, 2 hiz, 3 ones; mm[o][kind]
    task automatic run_frame(int f, bit mid_wr, logic [6:0] wa, logic [17:0] wd,
                             output int mm [2][4], output int mm60);
        for (int e = 0; e < 128; e++) snap[e] = shadow[e];
        for (int o = 0; o < 2; o++) for (int k = 0; k < 4; k++) mm[o][k] = 0;
        mm60 = 0;
        for (int k = 0; k < FRAME; k++) begin
            @(negedge clk);
            fp_i = (k == 0);
            host_we = 1'b0;
            if (mid_wr && k == 100) begin
                host_we = 1'b1; host_sel = 1'b0; host_addr = wa; host_wdata = wd;
                shadow[wa] = wd;
            end
            for (int s = 0; s < 2; s++) begin
                int c, b;
                c = rate_in[s] ? (k >> 3) : (k >> 4);
                b = rate_in[s] ? (k & 7) : ((k >> 1) & 7);
                ser_in[s] = pat(f, s, c)[7 - b];
            end
            @(posedge clk);
            #1;
            for (int o = 0; o < 2; o++) begin
                int c, b, kind;
                logic [17:0] e;
                logic eo, ev;
                logic [7:0] by;
                c = rate_out[o] ? (k >> 3) : (k >> 4);
                b = rate_out[o] ? (k & 7) : ((k >> 1) & 7);
                e = snap[o * 64 + c];
                kind = e[16] ? 2 : e[17] ? 3 : e[15] ? 1 : 0;
                by = e[15] ? e[7:0] : pat(f - 1, int'(e[14]), int'(e[13:8]));
                eo = (f > 0) && !e[16];
                ev = e[17] | by[7 - b];
                if (f == 0) kind = 2;
                if (ser_oe[o] !== eo || (eo && ser_out[o] !== ev)) begin
                    mm[o][kind]++;
                    if (o == 1 && c == 60) mm60++;
                end
            end
        end
        @(negedge clk);
        host_we = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int mm [2][4];
        int mm60;
        logic [17:0] rd;
        for (int e = 0; e < 128; e++) shadow[e] = 18'h10000;
        repeat (3) @(posedge clk);
        #1 chk(ser_oe == 2'b00, "R11 oe low in reset", ser_oe, 0);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        #1 chk(ser_oe == 2'b00, "R11 R6 oe low before pulses", ser_oe, 0);
        hread(1'b0, 7'd9, rd);
        chk(rd == 18'h10000, "R11 reset entry", rd, 18'h10000);

        for (int o = 0; o < 2; o++)
            for (int c = 0; c < 64; c++) begin
                int ss, sc;
                ss = c % 2;
                sc = (c * 5 + o) % 32;
                hwrite(1'b0, 7'(o * 64 + c), 18'((ss << 14) | (sc << 8)));
            end
        for (int v = 0; v < 8; v++)
            hwrite(1'b0, {VEC[v][24], VEC[v][23:18]}, VEC[v][17:0]);

        for (int f = 0; f < 5; f++) begin
            run_frame(f, f == 3, 7'd124, 18'h080A5, mm, mm60);
            if (f == 0) begin
                chk(mm[0][2] == 0, "R6 stream0 silent in first frame", mm[0][2], 0);
                chk(mm[1][2] == 0, "R6 stream1 silent in first frame", mm[1][2], 0);
            end else begin
                for (int o = 0; o < 2; o++) begin
                    chk(mm[o][0] == 0, $sformatf("R1 R5 switched f%0d o%0d", f, o), mm[o][0], 0);
                    chk(mm[o][1] == 0, $sformatf("R2 message f%0d o%0d", f, o), mm[o][1], 0);
                    chk(mm[o][2] == 0, $sformatf("R3 hiz f%0d o%0d", f, o), mm[o][2], 0);
                    chk(mm[o][3] == 0, $sformatf("R4 ones f%0d o%0d", f, o), mm[o][3], 0);
                end
                if (f >= 3) chk(mm60 == 0, $sformatf("R7 boundary f%0d", f), mm60, 0);
            end
        end

        hread(1'b0, 7'd124, rd);
        chk(rd == 18'h080A5, "R8 table read", rd, 18'h080A5);
        hread(1'b1, 7'd5, rd);
        chk(rd[7:0] == pat(3, 0, 5), "R9 store read s0", rd[7:0], pat(3, 0, 5));
        hread(1'b1, 7'd64 + 7'd17, rd);
        chk(rd[7:0] == pat(3, 1, 17), "R9 store read s1", rd[7:0], pat(3, 1, 17));
        hwrite(1'b1, 7'd5, 18'h3FFFF);
        hread(1'b1, 7'd5, rd);
        chk(rd[7:0] == pat(3, 0, 5), "R10 store untouched", rd[7:0], pat(3, 0, 5));
        hread(1'b0, 7'd5, rd);
        chk(rd == shadow[5], "R10 table untouched", rd, shadow[5]);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule